// File: doc/BRIEF.md
# Double-Buffer Frame Address Tracker

This block follows a frame-based transfer engine that alternates between two memory buffers, A and B. It keeps an internal working address. The working address advances by one 4-byte element on every element-done pulse. For each buffer the block also holds two registers that software can read: a current address and a remaining-frame count. These registers change only when a frame completes. While a frame is running, the address register therefore shows the start of that frame. Between frames it shows the start of the next frame. After the final frame of a buffer it shows the buffer end plus 4.

An enable write selects a buffer and loads that buffer's initial address and frame count into the working state. Loading the working state does not touch the visible registers. The visible registers of the selected buffer keep whatever software last wrote until its first frame completes. The same first-frame behaviour applies after an automatic switch to the other buffer and after a circular wrap back to the buffer start. If a frame is aborted, nothing is committed and the channel turns itself off. Software may preload any visible register in privileged mode. If a frame-completion commit hits the same register in the same cycle, the commit wins.

Top module: `dbuf_addr_track`

## Requirements
- R1: After reset, every visible register, the working address, `active` and `act_buf` are zero.
- R2: An element-done pulse inside a running frame adds 4 to `work_addr` and leaves the visible registers unchanged.
- R3: On frame completion, the active buffer's visible address takes the working address, which is the start of the next frame. Its visible count takes the remaining frames minus one. The other buffer's registers stay unchanged.
- R4: Completion of a buffer's last frame leaves its visible address at initial address + frames × elements-per-frame × 4, which is the end address plus 4, and its count at 0.
- R5: After an enable, an automatic switch or a circular wrap, the visible registers of the newly started buffer keep their prior value throughout the first frame and update only when that frame completes.
- R6: A frame abort commits nothing, clears `active`, and causes later frame and element events to be ignored until the next enable write.
- R7: When a buffer's last frame completes, `auto_switch`=1 moves to the other buffer, loading its initial values. Otherwise `circ_mode`=1 reloads the same buffer's initial values. If both are 0, `active` clears.
- R8: A write with `sw_we`=1 and `sw_priv`=1 loads `sw_wdata` into the register chosen by `sw_sel`, with 0 = address A, 1 = address B, 2 = count A and 3 = count B. With `sw_priv`=0 the write has no effect.
- R9: When a frame-completion commit and a privileged write target the same register in one cycle, the register takes the commit value.
- R10: An enable write sets `active`, sets `act_buf` to `en_sel` (0 = A, 1 = B), loads `work_addr` with that buffer's initial address, and cancels any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_addr_a | input | 32 | Initial byte address of buffer A |
| init_addr_b | input | 32 | Initial byte address of buffer B |
| frames_cfg | input | 16 | Frames per buffer |
| circ_mode | input | 1 | Wrap to buffer start at buffer end |
| auto_switch | input | 1 | Switch buffers at buffer end |
| en_wr | input | 1 | Enable write pulse |
| en_sel | input | 1 | Buffer chosen by the enable write |
| frame_start | input | 1 | Frame start event |
| elem_done | input | 1 | Element transferred event |
| frame_done | input | 1 | Frame completed event |
| frame_abort | input | 1 | Frame stopped before completion |
| sw_we | input | 1 | Software register write strobe |
| sw_priv | input | 1 | Write is privileged |
| sw_sel | input | 2 | Target register of the write |
| sw_wdata | input | 32 | Write data |
| cur_addr_a | output | 32 | Visible current address, buffer A |
| cur_addr_b | output | 32 | Visible current address, buffer B |
| cur_cnt_a | output | 16 | Visible remaining frames, buffer A |
| cur_cnt_b | output | 16 | Visible remaining frames, buffer B |
| active | output | 1 | Channel enabled |
| act_buf | output | 1 | Active buffer, 0 = A, 1 = B |
| work_addr | output | 32 | Internal working address |

## Verification
A working address that drifts shows up on `work_addr` one cycle after the element pulse. It reaches the visible address register only at the next frame completion. Wrong frame bookkeeping shows up later, when the last frame ends. A missed end of buffer leaves `act_buf` unchanged or `active` set. It also prevents the end-plus-4 value from appearing. A stray commit during a first frame overwrites a preloaded value one cycle after the event, so the preloaded marker is checked through every first frame.

// File: rtl/dbuf_addr_track.sv
module dbuf_addr_track #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int ESZ = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] init_addr_a,
  input  logic [AW-1:0] init_addr_b,
  input  logic [CW-1:0] frames_cfg,
  input  logic          circ_mode,
  input  logic          auto_switch,
  input  logic          en_wr,
  input  logic          en_sel,
  input  logic          frame_start,
  input  logic          elem_done,
  input  logic          frame_done,
  input  logic          frame_abort,
  input  logic          sw_we,
  input  logic          sw_priv,
  input  logic [1:0]    sw_sel,
  input  logic [AW-1:0] sw_wdata,
  output logic [AW-1:0] cur_addr_a,
  output logic [AW-1:0] cur_addr_b,
  output logic [CW-1:0] cur_cnt_a,
  output logic [CW-1:0] cur_cnt_b,
  output logic          active,
  output logic          act_buf,
  output logic [AW-1:0] work_addr
);

  logic          in_frame_q;
  logic [CW-1:0] left_q;

  wire go     = active & ~en_wr;
  wire fs_ok  = go & frame_start & ~in_frame_q;
  wire fd_ok  = go & frame_done & in_frame_q;
  wire ab_ok  = go & frame_abort & in_frame_q & ~frame_done;
  wire ed_ok  = go & elem_done & in_frame_q & ~frame_abort;
  wire sw_ok  = sw_we & sw_priv;

  wire [AW-1:0] next_addr = work_addr + (ed_ok ? AW'(ESZ) : '0);
  wire [CW-1:0] left_dec  = (left_q == '0) ? '0 : left_q - 1'b1;
  wire          last      = (left_q <= CW'(1));
  wire          commit_a  = fd_ok & ~act_buf;
  wire          commit_b  = fd_ok & act_buf;

  wire [AW-1:0] sel_init  = en_sel ? init_addr_b : init_addr_a;
  wire [AW-1:0] same_init = act_buf ? init_addr_b : init_addr_a;
  wire [AW-1:0] othr_init = act_buf ? init_addr_a : init_addr_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      act_buf    <= 1'b0;
      in_frame_q <= 1'b0;
      work_addr  <= '0;
      left_q     <= '0;
    end else if (en_wr) begin
      active     <= 1'b1;
      act_buf    <= en_sel;
      in_frame_q <= 1'b0;
      work_addr  <= sel_init;
      left_q     <= frames_cfg;
    end else if (fs_ok) begin
      in_frame_q <= 1'b1;
    end else if (fd_ok) begin
      in_frame_q <= 1'b0;
      if (!last) begin
        work_addr <= next_addr;
        left_q    <= left_dec;
      end else if (auto_switch) begin
        act_buf   <= ~act_buf;
        work_addr <= othr_init;
        left_q    <= frames_cfg;
      end else if (circ_mode) begin
        work_addr <= same_init;
        left_q    <= frames_cfg;
      end else begin
        active    <= 1'b0;
        work_addr <= next_addr;
        left_q    <= '0;
      end
    end else if (ab_ok) begin
      in_frame_q <= 1'b0;
      active     <= 1'b0;
    end else if (ed_ok) begin
      work_addr <= next_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr_a <= '0;
      cur_addr_b <= '0;
      cur_cnt_a  <= '0;
      cur_cnt_b  <= '0;
    end else begin
      if (commit_a) begin
        cur_addr_a <= next_addr;
        cur_cnt_a  <= left_dec;
      end else begin
        if (sw_ok && sw_sel == 2'd0) cur_addr_a <= sw_wdata;
        if (sw_ok && sw_sel == 2'd2) cur_cnt_a  <= sw_wdata[CW-1:0];
      end
      if (commit_b) begin
        cur_addr_b <= next_addr;
        cur_cnt_b  <= left_dec;
      end else begin
        if (sw_ok && sw_sel == 2'd1) cur_addr_b <= sw_wdata;
        if (sw_ok && sw_sel == 2'd3) cur_cnt_b  <= sw_wdata[CW-1:0];
      end
    end
  end

endmodule

module dbuf_addr_track_chk #(
  parameter int AW  = 32,
  parameter int ESZ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_wr,
  input logic          elem_done,
  input logic          frame_done,
  input logic          frame_abort,
  input logic          sw_we,
  input logic          sw_priv,
  input logic          in_frame_q,
  input logic          active,
  input logic [AW-1:0] work_addr,
  input logic [AW-1:0] cur_addr_a,
  input logic [AW-1:0] cur_addr_b
);

  // R2
  elem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_frame_q && elem_done && !en_wr && !frame_done && !frame_abort)
      |=> (work_addr == $past(work_addr) + AW'(ESZ)));

  // R3
  addr_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !(sw_we && sw_priv)) |=> $stable(cur_addr_a));

  // R3
  addr_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !(sw_we && sw_priv)) |=> $stable(cur_addr_b));

  // R6
  abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && in_frame_q && frame_abort && !frame_done && !en_wr) |=> !active);

  // R8
  user_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !sw_priv && !frame_done) |=> ($stable(cur_addr_a) && $stable(cur_addr_b)));

  // R1
  idle_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !in_frame_q);

endmodule

bind dbuf_addr_track dbuf_addr_track_chk #(.AW(AW), .ESZ(ESZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .elem_done(elem_done),
  .frame_done(frame_done), .frame_abort(frame_abort), .sw_we(sw_we),
  .sw_priv(sw_priv), .in_frame_q(in_frame_q), .active(active),
  .work_addr(work_addr), .cur_addr_a(cur_addr_a), .cur_addr_b(cur_addr_b)
);

// File: tb/dbuf_addr_track_bench.sv
`timescale 1ns/1ps
module dbuf_addr_track_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] init_addr_a = 32'h1000;
  logic [31:0] init_addr_b = 32'h2000;
  logic [15:0] frames_cfg = 16'd2;
  logic        circ_mode = 1'b0, auto_switch = 1'b1;
  logic        en_wr = 0, en_sel = 0, frame_start = 0, elem_done = 0;
  logic        frame_done = 0, frame_abort = 0, sw_we = 0, sw_priv = 0;
  logic [1:0]  sw_sel = 0;
  logic [31:0] sw_wdata = 0;
  logic [31:0] cur_addr_a, cur_addr_b, work_addr;
  logic [15:0] cur_cnt_a, cur_cnt_b;
  logic        active, act_buf;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dbuf_addr_track u_dbuf_addr_track (.*);

  localparam logic [3:0] NOP = 0, EN = 1, FS = 2, ED = 3, FD = 4, FA = 5, SWP = 6, SWU = 7;
  localparam int N = 31;
  // {op, arg, sel (write target and register checked), expected}
  localparam logic [69:0] VEC [N] = '{
    {SWP, 32'h0000AAAA, 2'd0, 32'h0000AAAA},
    {SWP, 32'h0000BBBB, 2'd1, 32'h0000BBBB},
    {EN,  32'd0,        2'd0, 32'h0000AAAA},
    {FS,  32'd0,        2'd0, 32'h0000AAAA},
    {ED,  32'd0,        2'd0, 32'h0000AAAA},
    {ED,  32'd0,        2'd0, 32'h0000AAAA},
    {FD,  32'd0,        2'd0, 32'h00001008},
    {NOP, 32'd0,        2'd2, 32'd1},
    {FS,  32'd0,        2'd0, 32'h00001008},
    {ED,  32'd0,        2'd0, 32'h00001008},
    {ED,  32'd0,        2'd0, 32'h00001008},
    {FD,  32'd0,        2'd0, 32'h00001010},
    {NOP, 32'd0,        2'd2, 32'd0},
    {NOP, 32'd0,        2'd1, 32'h0000BBBB},
    {FS,  32'd0,        2'd1, 32'h0000BBBB},
    {ED,  32'd0,        2'd1, 32'h0000BBBB},
    {ED,  32'd0,        2'd1, 32'h0000BBBB},
    {FD,  32'd0,        2'd1, 32'h00002008},
    {NOP, 32'd0,        2'd0, 32'h00001010},
    {SWU, 32'h00005555, 2'd0, 32'h00001010},
    {FS,  32'd0,        2'd1, 32'h00002008},
    {ED,  32'd0,        2'd1, 32'h00002008},
    {FA,  32'd0,        2'd1, 32'h00002008},
    {FS,  32'd0,        2'd1, 32'h00002008},
    {ED,  32'd0,        2'd1, 32'h00002008},
    {FD,  32'd0,        2'd1, 32'h00002008},
    {EN,  32'd1,        2'd1, 32'h00002008},
    {FS,  32'd0,        2'd1, 32'h00002008},
    {ED,  32'd0,        2'd1, 32'h00002008},
    {FD,  32'd0,        2'd1, 32'h00002004},
    {NOP, 32'd0,        2'd3, 32'd1}
  };
  // R8 R5 R2 R3 R4 R7 R6 R10 exercised by the table rows above

  function automatic logic [31:0] rd(input logic [1:0] s);
    case (s)
      2'd0: rd = cur_addr_a;
      2'd1: rd = cur_addr_b;
      2'd2: rd = {16'd0, cur_cnt_a};
      default: rd = {16'd0, cur_cnt_b};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    en_wr = 0; frame_start = 0; elem_done = 0; frame_done = 0;
    frame_abort = 0; sw_we = 0; sw_priv = 0;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] arg, input logic [1:0] s);
    @(negedge clk);
    case (op)
      EN:  begin en_wr = 1; en_sel = arg[0]; end
      FS:  frame_start = 1;
      ED:  elem_done = 1;
      FD:  frame_done = 1;
      FA:  frame_abort = 1;
      SWP: begin sw_we = 1; sw_priv = 1; sw_sel = s; sw_wdata = arg; end
      SWU: begin sw_we = 1; sw_priv = 0; sw_sel = s; sw_wdata = arg; end
      default: ;
    endcase
    @(negedge clk);
    clr();
  endtask

  task automatic frame2();
    do_op(FS, 0, 0); do_op(ED, 0, 0); do_op(ED, 0, 0); do_op(FD, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr_a", cur_addr_a, 0);
    chk("R1 addr_b", cur_addr_b, 0);
    chk("R1 cnt", {cur_cnt_a, cur_cnt_b}, 0);
    chk("R1 flags", {30'd0, active, act_buf}, 0);
    chk("R1 work", work_addr, 0);
    rst_n = 1;

    for (int i = 0; i < N; i++) begin
      do_op(VEC[i][69:66], VEC[i][65:34], VEC[i][33:32]);
      chk($sformatf("R3 R5 R6 vec%0d", i), rd(VEC[i][33:32]), VEC[i][31:0]);
      if (i == 22) chk("R6 active after abort", {31'd0, active}, 0);
      if (i == 11) chk("R7 switch to B", {31'd0, act_buf}, 1);
      if (i == 26) chk("R10 enable B", {30'd0, active, act_buf}, 3);
      if (i == 26) chk("R10 work reload", work_addr, 32'h2000);
    end

    // circular mode, no auto-switch
    @(negedge clk); rst_n = 0; circ_mode = 1; auto_switch = 0;
    @(negedge clk); rst_n = 1;
    do_op(EN, 0, 0);
    do_op(FS, 0, 0); do_op(ED, 0, 0);
    chk("R2 work step", work_addr, 32'h1004);
    chk("R2 visible held", cur_addr_a, 0);
    do_op(ED, 0, 0); do_op(FD, 0, 0);
    frame2();
    chk("R4 end plus 4", cur_addr_a, 32'h1010);
    chk("R4 count zero", {16'd0, cur_cnt_a}, 0);
    chk("R7 wrap stays on A", {30'd0, active, act_buf}, 2);
    chk("R7 wrap reload", work_addr, 32'h1000);
    do_op(SWP, 32'h7777, 0);
    do_op(FS, 0, 0); do_op(ED, 0, 0); do_op(ED, 0, 0);
    chk("R5 first frame after wrap", cur_addr_a, 32'h7777);
    @(negedge clk);
    frame_done = 1; sw_we = 1; sw_priv = 1; sw_sel = 0; sw_wdata = 32'h9999;
    @(negedge clk); clr();
    chk("R9 commit beats write", cur_addr_a, 32'h1008);
    circ_mode = 0;
    frame2();
    chk("R7 stop at end", {31'd0, active}, 0);
    chk("R4 end plus 4 final", cur_addr_a, 32'h1010);
    do_op(SWP, 32'h00000042, 3);
    chk("R8 count write", {16'd0, cur_cnt_b}, 32'h42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule